// File: doc/BRIEF.md
# I2C Serial EEPROM Target Interface

This block is the bus-facing half of a two-wire serial memory. It watches an already synchronised SCL and SDA pair and recognises START and STOP conditions. After a START it collects an address byte and answers only when the upper nibble is `1010` and the next three bits equal the `strap_i` inputs. It then runs a byte or page write, a random read, a current read or a sequential read. It pulls SDA low through an open-drain enable, both for acknowledge bits and for the zero bits of read data. The memory array sits outside the block. Reads use a combinational port (`rd_addr_o` / `rd_data_i`). Writes are handed one byte at a time to a separate page-write engine, which also reports a busy flag back.

A persistent address counter remembers where the last access ended, so a read sent without a word address continues from there. A write counter step wraps inside a page of `2**PAGE_W` bytes. A read step wraps over the whole `2**ADDR_W` space. While the engine reports busy, every address byte is left unacknowledged, so the master can poll for completion. A STOP commits the write data received since the last START. A START followed directly by a STOP throws that data away.

The controller has these states: `ST_IDLE`, `ST_DEVADDR`, `ST_DEV_ACK`, `ST_WORDADDR`, `ST_WA_ACK`, `ST_WRDATA`, `ST_WD_ACK`, `ST_RDDATA`, `ST_RD_ACK` and `ST_WAIT_STOP`. A START moves any state to `ST_DEVADDR`, and a STOP moves any state to `ST_IDLE`. The remaining transitions all happen on an SCL falling edge, except where noted:
- `ST_DEVADDR` goes to `ST_DEV_ACK` when the address matches and the engine is not busy. Otherwise it goes to `ST_IDLE`.
- `ST_DEV_ACK` goes to `ST_RDDATA` for a read and to `ST_WORDADDR` for a write.
- `ST_WORDADDR` goes to `ST_WA_ACK`, and `ST_WA_ACK` goes to `ST_WRDATA`.
- `ST_WRDATA` goes to `ST_WD_ACK`, and `ST_WD_ACK` goes back to `ST_WRDATA`.
- `ST_RDDATA` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes back to `ST_RDDATA` when the master acknowledges. When the master sends SDA high on the SCL rising edge, it goes to `ST_WAIT_STOP` instead.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Nothing is acknowledged unless a START came first. After reset `sda_oe_o`, `wr_req_o` and `wr_commit_o` are 0.
- R2: The address byte is sent MSB first. Bits 7..4 must be `1010`, bits 3..1 must equal `strap_i[2:0]`, and bit 0 selects write (0) or read (1).
- R3: Bits are sampled on SCL rising edges. The block drives SDA low for the whole ninth clock after a matching address byte, after a word-address byte and after every write-data byte. Its output changes only while SCL is low.
- R4: Each received data byte produces a one-cycle `wr_req_o` carrying the current address and the byte. A STOP produces a one-cycle `wr_commit_o` if at least one data byte arrived since the last START.
- R5: During a write the address steps only its low `PAGE_W` bits. With 8-byte pages, a write starting at 0x06 goes to 0x06, 0x07 and then 0x00.
- R6: A write header plus a word address, followed by a repeated START and a read header, returns data from that word address.
- R7: A read with no word address returns the byte at the last accessed address plus one. This holds after a read and after a write.
- R8: A master ACK (SDA low) after a read byte makes the block send the next address. Read stepping wraps from the top address to 0.
- R9: A master NACK (SDA high) ends the output. SDA stays released for any further clocks until a STOP.
- R10: The address byte is not acknowledged when `wr_busy_i` is high in the first clock that sees SCL low after the eighth address bit.
- R11: A START followed directly by a STOP after write data abandons the command, and no commit is issued.
- R12: A repeated START inside a transaction restarts address matching without needing a STOP.
- R13: A non-matching address leaves SDA released, and nothing in the same transaction is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Device select straps compared with address bits 3..1 |
| wr_busy_i | input | 1 | Page-write engine is programming |
| wr_req_o | output | 1 | One-cycle pulse: a data byte is ready for the engine |
| wr_addr_o | output | ADDR_W | Target address of the byte in `wr_req_o` |
| wr_data_o | output | 8 | Data byte of `wr_req_o` |
| wr_commit_o | output | 1 | One-cycle pulse: start programming the staged bytes |
| rd_addr_o | output | ADDR_W | Current address, driven to the memory read port |
| rd_data_i | input | 8 | Memory read data for `rd_addr_o` |

## Verification
Two functions can meet in the same clock: the acknowledge decision on the eighth address bit and a change of the engine's busy flag. The bench holds busy high and releases it one clock before, exactly on, and one clock after the clock in which SCL is driven low after the eighth address bit. It expects an ACK in the first two cases and a released SDA in the third. The bench's own engine model also raises busy after each commit, and polling during that window must find the address unacknowledged.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    // device code carried in address bits 7..4
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_WORDADDR,
        ST_WA_ACK,
        ST_WRDATA,
        ST_WD_ACK,
        ST_RDDATA,
        ST_RD_ACK,
        ST_WAIT_STOP
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    // idle bus reads high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
    parameter int WIDTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_i,
    input  logic                           load_i,
    input  logic [WIDTH-1:0]               load_val_i,
    input  logic                           shift_i,
    input  logic                           bit_i,
    output logic [WIDTH-1:0]               data_o,
    output logic [$clog2(WIDTH+1)-1:0]     cnt_o
);

    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] data_q;
    logic [CNT_W-1:0] cnt_q;

    // one register serves both directions: MSB is the bit on the wire
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (clr_i) begin
            cnt_q  <= '0;
        end else if (load_i) begin
            data_q <= load_val_i;
            cnt_q  <= '0;
        end else if (shift_i) begin
            data_q <= {data_q[WIDTH-2:0], bit_i};
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign data_o = data_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_page_i,
    input  logic              step_full_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] page_next;
    logic [ADDR_W-1:0] full_next;

    assign full_next = addr_q + ADDR_W'(1);

    generate
        if (PAGE_W <= 0 || PAGE_W >= ADDR_W) begin : g_flat
            assign page_next = full_next;
        end else begin : g_page
            assign page_next = {addr_q[ADDR_W-1:PAGE_W],
                                addr_q[PAGE_W-1:0] + PAGE_W'(1)};

            // R5: a page step never touches the page-select bits
            a_r5_page_bits_hold: assert property (
                @(posedge clk) disable iff (!rst_n)
                (step_page_i && !load_i) |=>
                    addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]))
                else $error("page step changed upper address bits");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_val_i;
        end else if (step_page_i) begin
            addr_q <= page_next;
        end else if (step_full_i) begin
            addr_q <= full_next;
        end
    end

    assign addr_o = addr_q;

    // R8: a full step from the top address lands on zero
    a_r8_top_wraps: assert property (
        @(posedge clk) disable iff (!rst_n)
        (step_full_i && !load_i && !step_page_i && addr_q == {ADDR_W{1'b1}})
            |=> addr_q == '0)
        else $error("read step did not wrap to zero");

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_eeprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              wr_busy_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              wr_commit_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    // ---------------------------------------------------------------
    // line events
    // ---------------------------------------------------------------
    logic ev_rise, ev_fall, ev_start, ev_stop;

    i2c_line_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (ev_rise),
        .scl_fall_o (ev_fall),
        .start_o    (ev_start),
        .stop_o     (ev_stop)
    );

    // ---------------------------------------------------------------
    // shifter and address counter
    // ---------------------------------------------------------------
    logic              sh_clr, sh_load, sh_shift;
    logic [BYTE_W-1:0] sh_data;
    logic [CNT_W-1:0]  sh_cnt;

    i2c_byte_shifter #(.WIDTH(BYTE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sh_clr),
        .load_i     (sh_load),
        .load_val_i (rd_data_i),
        .shift_i    (sh_shift),
        .bit_i      (sda_i),
        .data_o     (sh_data),
        .cnt_o      (sh_cnt)
    );

    logic              ac_load, ac_step_page, ac_step_full;
    logic [ADDR_W-1:0] cur_addr;

    i2c_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ac_load),
        .load_val_i  (sh_data[ADDR_W-1:0]),
        .step_page_i (ac_step_page),
        .step_full_i (ac_step_full),
        .addr_o      (cur_addr)
    );

    // ---------------------------------------------------------------
    // decode
    // ---------------------------------------------------------------
    tgt_state_t state, nstate;
    logic       sda_oe_q, oe_nxt;
    logic       rw_q, pend_q;
    logic       rw_capture, req_fire, commit_fire;
    logic       byte_done, addr_match;

    assign byte_done  = (sh_cnt == CNT_FULL);
    assign addr_match = (sh_data[7:4] == DEV_CODE) && (sh_data[3:1] == strap_i);

    always_comb begin
        nstate       = state;
        oe_nxt       = sda_oe_q;
        sh_clr       = 1'b0;
        sh_load      = 1'b0;
        sh_shift     = 1'b0;
        ac_load      = 1'b0;
        ac_step_page = 1'b0;
        ac_step_full = 1'b0;
        rw_capture   = 1'b0;
        req_fire     = 1'b0;
        commit_fire  = 1'b0;
        if (ev_start) begin
            nstate = ST_DEVADDR;
            sh_clr = 1'b1;
            oe_nxt = 1'b0;
        end else if (ev_stop) begin
            nstate      = ST_IDLE;
            oe_nxt      = 1'b0;
            commit_fire = pend_q;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    nstate = ST_IDLE;
                end
                ST_DEVADDR: begin
                    if (ev_rise && !byte_done) begin
                        sh_shift = 1'b1;
                    end else if (ev_fall && byte_done) begin
                        if (addr_match && !wr_busy_i) begin
                            nstate     = ST_DEV_ACK;
                            oe_nxt     = 1'b1;
                            rw_capture = 1'b1;
                        end else begin
                            nstate = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev_fall) begin
                        if (rw_q) begin
                            nstate  = ST_RDDATA;
                            sh_load = 1'b1;
                            oe_nxt  = ~rd_data_i[7];
                        end else begin
                            nstate = ST_WORDADDR;
                            sh_clr = 1'b1;
                            oe_nxt = 1'b0;
                        end
                    end
                end
                ST_WORDADDR: begin
                    if (ev_rise && !byte_done) begin
                        sh_shift = 1'b1;
                    end else if (ev_fall && byte_done) begin
                        nstate  = ST_WA_ACK;
                        oe_nxt  = 1'b1;
                        ac_load = 1'b1;
                    end
                end
                ST_WA_ACK: begin
                    if (ev_fall) begin
                        nstate = ST_WRDATA;
                        sh_clr = 1'b1;
                        oe_nxt = 1'b0;
                    end
                end
                ST_WRDATA: begin
                    if (ev_rise && !byte_done) begin
                        sh_shift = 1'b1;
                    end else if (ev_fall && byte_done) begin
                        nstate       = ST_WD_ACK;
                        oe_nxt       = 1'b1;
                        req_fire     = 1'b1;
                        ac_step_page = 1'b1;
                    end
                end
                ST_WD_ACK: begin
                    if (ev_fall) begin
                        nstate = ST_WRDATA;
                        sh_clr = 1'b1;
                        oe_nxt = 1'b0;
                    end
                end
                ST_RDDATA: begin
                    if (ev_fall) begin
                        if (sh_cnt == CNT_LAST) begin
                            nstate       = ST_RD_ACK;
                            oe_nxt       = 1'b0;
                            ac_step_full = 1'b1;
                        end else begin
                            sh_shift = 1'b1;
                            oe_nxt   = ~sh_data[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise && sda_i) begin
                        nstate = ST_WAIT_STOP;
                    end else if (ev_fall) begin
                        nstate  = ST_RDDATA;
                        sh_load = 1'b1;
                        oe_nxt  = ~rd_data_i[7];
                    end
                end
                ST_WAIT_STOP: begin
                    nstate = ST_WAIT_STOP;
                end
                default: begin
                    nstate = ST_IDLE;
                    oe_nxt = 1'b0;
                end
            endcase
        end
    end

    // ---------------------------------------------------------------
    // state register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // ---------------------------------------------------------------
    // outputs
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_q    <= 1'b0;
            rw_q        <= 1'b0;
            pend_q      <= 1'b0;
            wr_req_o    <= 1'b0;
            wr_commit_o <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
        end else begin
            sda_oe_q    <= oe_nxt;
            wr_req_o    <= req_fire;
            wr_commit_o <= commit_fire;
            if (rw_capture) begin
                rw_q <= sh_data[0];
            end
            if (req_fire) begin
                wr_addr_o <= cur_addr;
                wr_data_o <= sh_data;
            end
            if (ev_start || commit_fire) begin
                pend_q <= 1'b0;
            end else if (req_fire) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign sda_oe_o  = sda_oe_q;
    assign rd_addr_o = cur_addr;

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    // R1 / R12: any START, first or repeated, restarts address matching
    a_r12_start_to_addr: assert property (
        @(posedge clk) disable iff (!rst_n)
        ev_start |=> state == ST_DEVADDR)
        else $error("START did not restart address matching");

    // R10: busy during the address byte never yields an ACK
    a_r10_busy_no_ack: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_DEVADDR && wr_busy_i) |=> !sda_oe_o)
        else $error("address acknowledged while busy");

    // R9: after a master NACK the line stays released
    a_r9_released_wait: assert property (
        @(posedge clk) disable iff (!rst_n)
        state == ST_WAIT_STOP |-> !sda_oe_o)
        else $error("SDA driven while waiting for STOP");

    // R13: the idle target never holds SDA
    a_r13_idle_released: assert property (
        @(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe_o)
        else $error("SDA driven in idle");

    // R4: a commit only follows a STOP, and requests are single pulses
    a_r4_commit_after_stop: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(ev_stop))
        else $error("commit without STOP");

    a_r4_req_one_cycle: assert property (
        @(posedge clk) disable iff (!rst_n)
        wr_req_o |=> !wr_req_o)
        else $error("write request longer than one cycle");

    // R3: the driven level only changes while SCL is low
    a_r3_change_scl_low: assert property (
        @(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(ev_start) && !$past(ev_stop))
            |-> $stable(sda_oe_o))
        else $error("SDA output changed while SCL high");

endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int BUSY_CYC   = 400;
    localparam int AW         = 8;
    localparam logic [7:0] DEV_W = 8'hAA;   // 1010 101 0
    localparam logic [7:0] DEV_R = 8'hAB;   // 1010 101 1

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          rst_n;
    logic          scl_m, sda_m;
    logic [2:0]    strap;
    logic          busy_eng, busy_man, wr_busy;
    logic          sda_oe, wr_req, wr_commit;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0]    wr_data, rd_data;
    logic [7:0]    mem_m [0:255];
    logic          quiet;
    logic          done;

    wire sda_line = sda_m & ~sda_oe;
    assign wr_busy = busy_eng | busy_man;
    assign rd_data = mem_m[rd_addr];

    int checks = 0;
    int errors = 0;
    int start_cnt = 0;
    int commits = 0;
    int obs_addr[$];
    int obs_data[$];

    i2c_eeprom_target #(.ADDR_W(AW), .PAGE_W(3)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_i     (strap),
        .wr_busy_i   (wr_busy),
        .wr_req_o    (wr_req),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // page-write engine model: stages requests, applies them on commit
    int stage_a[$];
    int stage_d[$];
    int start_seen = 0;
    int bcnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem_m[i] = init_val(i);
            busy_eng = 1'b0;
            bcnt = 0;
        end else begin
            if (start_seen != start_cnt) begin
                stage_a.delete();
                stage_d.delete();
                start_seen = start_cnt;
            end
            if (wr_req) begin
                stage_a.push_back(int'(wr_addr));
                stage_d.push_back(int'(wr_data));
                obs_addr.push_back(int'(wr_addr));
                obs_data.push_back(int'(wr_data));
            end
            if (wr_commit) begin
                foreach (stage_a[k]) mem_m[stage_a[k]] = 8'(stage_d[k]);
                stage_a.delete();
                stage_d.delete();
                commits++;
                busy_eng = 1'b1;
                bcnt = BUSY_CYC;
            end else if (bcnt > 0) begin
                bcnt--;
                if (bcnt == 0) busy_eng = 1'b0;
            end
        end
    end

    // per-clock check: the target stays off the line while the master sends
    always @(negedge clk) begin
        if (rst_n && quiet && scl_m) begin
            checks++;
            if (sda_oe) begin
                errors++;
                $display("FAIL R3 target drove SDA during master bit actual=1 expected=0");
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
        start_cnt++;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        seen  = sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req);
        logic s;
        quiet = 1'b1;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        quiet = 1'b0;
        clk_bit(1'b1, s);
        chk(req, int'(s), exp_ack ? 0 : 1);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string req);
        logic s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            got[i] = s;
        end
        clk_bit(~mack, s);
        chk(req, int'(got), int'(exp));
    endtask

    task automatic wait_idle();
        tick(4);
        while (wr_busy) tick(1);
        tick(4);
    endtask

    // address byte whose busy release is placed d clocks from the 8th SCL fall
    task automatic addr_busy_edge(input logic [7:0] v, input int d, input logic exp_ack, input string req);
        logic s;
        for (int i = 7; i >= 1; i--) clk_bit(v[i], s);
        sda_m = v[0]; tick(Q);
        scl_m = 1'b1; tick(2 * Q - 1);
        if (d < 0) busy_man = 1'b0;
        tick(1);
        scl_m = 1'b0;
        if (d == 0) busy_man = 1'b0;
        tick(1);
        if (d > 0) busy_man = 1'b0;
        tick(Q - 1);
        clk_bit(1'b1, s);
        chk(req, int'(s), exp_ack ? 0 : 1);
    endtask

    initial begin
        int base;
        int c0;
        logic s;
        done = 1'b0;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        strap = 3'b101; busy_man = 1'b0; quiet = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk("R1 reset sda_oe", int'(sda_oe), 0);
        chk("R4 reset wr_req", int'(wr_req), 0);
        chk("R4 reset wr_commit", int'(wr_commit), 0);

        // R1: a valid header without START is ignored
        scl_m = 1'b0; tick(Q);
        send_byte(DEV_W, 1'b0, "R1 no ACK without START");
        bus_stop();

        // R2 R3 R4: byte write 0xA5 at 0x10
        base = obs_addr.size(); c0 = commits;
        bus_start();
        send_byte(DEV_W, 1'b1, "R2 matching write header ACK");
        send_byte(8'h10, 1'b1, "R3 word address ACK");
        send_byte(8'hA5, 1'b1, "R3 data byte ACK");
        bus_stop();
        tick(4);
        chk("R4 one request", obs_addr.size() - base, 1);
        chk("R4 request address", obs_addr[base], 'h10);
        chk("R4 request data", obs_data[base], 'hA5);
        chk("R4 one commit", commits - c0, 1);

        // R10: polling while the engine is busy
        bus_start();
        send_byte(DEV_W, 1'b0, "R10 no ACK while busy");
        bus_stop();
        wait_idle();

        // R6 R12: random read of 0x10 through a repeated START
        bus_start();
        send_byte(DEV_W, 1'b1, "R6 header ACK");
        send_byte(8'h10, 1'b1, "R6 word address ACK");
        bus_start();
        send_byte(DEV_R, 1'b1, "R12 repeated START header ACK");
        recv_byte(8'hA5, 1'b0, "R6 random read data");
        bus_stop();

        // R7: current read after a read continues at 0x11
        bus_start();
        send_byte(DEV_R, 1'b1, "R7 current read header ACK");
        recv_byte(init_val('h11), 1'b0, "R7 current read after read");
        bus_stop();

        // R5: page write from 0x06 wraps inside the page
        base = obs_addr.size();
        bus_start();
        send_byte(DEV_W, 1'b1, "R5 header ACK");
        send_byte(8'h06, 1'b1, "R5 word address ACK");
        send_byte(8'h11, 1'b1, "R5 data0 ACK");
        send_byte(8'h22, 1'b1, "R5 data1 ACK");
        send_byte(8'h33, 1'b1, "R5 data2 ACK");
        bus_stop();
        tick(4);
        chk("R5 request count", obs_addr.size() - base, 3);
        chk("R5 first address", obs_addr[base], 'h06);
        chk("R5 second address", obs_addr[base + 1], 'h07);
        chk("R5 wrapped address", obs_addr[base + 2], 'h00);
        wait_idle();

        // R7: current read after the page write reads 0x01
        bus_start();
        send_byte(DEV_R, 1'b1, "R7 header ACK after write");
        recv_byte(init_val('h01), 1'b0, "R7 current read after write");
        bus_stop();

        // R8 R9: sequential read from 0xFE through the top, then NACK
        bus_start();
        send_byte(DEV_W, 1'b1, "R8 header ACK");
        send_byte(8'hFE, 1'b1, "R8 word address ACK");
        bus_start();
        send_byte(DEV_R, 1'b1, "R8 read header ACK");
        recv_byte(init_val('hFE), 1'b1, "R8 byte at 0xFE");
        recv_byte(init_val('hFF), 1'b1, "R8 byte at 0xFF");
        recv_byte(8'h33, 1'b0, "R8 wrapped byte at 0x00");
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b1, s);
            chk("R9 released after NACK", int'(s), 1);
        end
        bus_stop();

        // R13 R2: wrong strap and wrong device code
        bus_start();
        send_byte(8'hA0, 1'b0, "R13 strap mismatch NACK");
        send_byte(8'h55, 1'b0, "R13 later byte NACK");
        bus_stop();
        bus_start();
        send_byte(8'hBA, 1'b0, "R2 device code mismatch NACK");
        bus_stop();

        // R11: START then STOP after write data abandons it
        c0 = commits;
        bus_start();
        send_byte(DEV_W, 1'b1, "R11 header ACK");
        send_byte(8'h20, 1'b1, "R11 word address ACK");
        send_byte(8'h77, 1'b1, "R11 data ACK");
        bus_start();
        bus_stop();
        tick(4);
        chk("R11 no commit", commits - c0, 0);
        chk("R11 engine idle", int'(wr_busy), 0);
        bus_start();
        send_byte(DEV_W, 1'b1, "R11 readback header ACK");
        send_byte(8'h20, 1'b1, "R11 readback address ACK");
        bus_start();
        send_byte(DEV_R, 1'b1, "R11 readback read ACK");
        recv_byte(init_val('h20), 1'b0, "R11 data unchanged");
        bus_stop();

        // R10: busy released around the decision clock
        for (int d = -1; d <= 1; d++) begin
            busy_man = 1'b1;
            tick(2);
            bus_start();
            addr_busy_edge(DEV_W, d, (d <= 0), "R10 busy release at decision edge");
            bus_stop();
            busy_man = 1'b0;
            tick(4);
        end

        done = 1'b0;
        tick(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule